// File: doc/BRIEF.md
# Paged Table-Read Address Unit

This unit executes the table-lookup instructions of a small nibble-oriented processor. Such an instruction fetches one 8-bit constant from program memory. The offset within a 256-word page comes from two 4-bit working registers: the high register supplies the upper nibble of the offset and the low register the lower nibble. The page is either the page of the program counter or the fixed last page of program memory, depending on the instruction variant.

The processor hands the unit the page bits of the program counter after the counter has already moved past the lookup instruction. As a result, a lookup placed in the last word of a page reads from the following page. The unit spends one extra cycle on the memory access, and it holds the program counter during that cycle. In the cycle after that, it splits the fetched byte. The low nibble always goes to the accumulator. The high nibble goes either to working register four or to the data-RAM word whose address is the register pair. That address is latched when the instruction is accepted.

Top module: `trd_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `rom_rd`, `hold_pc`, `acc_we`, `r4_we` and `ram_we` are all 0.
- R2: When `start` is sampled high at a clock edge while no read cycle is in progress, the following cycle has `rom_rd`=1 and `hold_pc`=1 for exactly one cycle. With `sel_last`=0, `rom_addr` = {`pc_page`, `r1`, `r0`} in that cycle.
- R3: With `sel_last`=1, `rom_addr` in the read cycle is {all ones, `r1`, `r0`}, so the page is the last page whatever `pc_page` holds.
- R4: The page is used exactly as presented on `pc_page` (the already-advanced program counter). A `pc_page` of 1 given for a lookup that sits at the end of page 0 reads page 1.
- R5: `rom_data` is sampled at the edge that ends the read cycle. With `to_ram`=0, the cycle after that has `acc_we`=1 with `acc_wdata` = `rom_data[3:0]`, and `r4_we`=1 with `r4_wdata` = `rom_data[7:4]`. In that case `ram_we` stays 0.
- R6: With `to_ram`=1, the write cycle has `acc_we`=1 carrying the low nibble, and `ram_we`=1 carrying the high nibble on `ram_wdata`. `ram_addr` = {`r1`, `r0`} and `r4_we` stays 0.
- R7: `ram_addr` and the lookup address are latched at the accepting edge. Changing `r1`, `r0`, `sel_last` or `to_ram` afterwards has no effect on that instruction's read or write.
- R8: The read cycle lasts exactly one cycle and is always followed by the write cycle. A new `start` is accepted in the write cycle, so lookups can run back to back.
- R9: A `start` sampled during a read cycle is ignored. It neither changes `rom_addr` nor adds a read or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Lookup instruction issued this cycle |
| sel_last | input | 1 | 1: read the last page; 0: read the program counter's page |
| to_ram | input | 1 | 1: high nibble to data RAM; 0: high nibble to register four |
| pc_page | input | 4 | Page bits of the already-advanced program counter |
| r0 | input | 4 | Low offset register |
| r1 | input | 4 | High offset register |
| rom_data | input | 8 | Program memory data, registered by memory one cycle after `rom_rd` |
| rom_addr | output | 12 | Program memory address |
| rom_rd | output | 1 | Program memory read strobe |
| hold_pc | output | 1 | Freeze the program counter this cycle |
| acc_we | output | 1 | Accumulator write enable |
| acc_wdata | output | 4 | Accumulator write data |
| r4_we | output | 1 | Register four write enable |
| r4_wdata | output | 4 | Register four write data |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | 8 | Data RAM write address |
| ram_wdata | output | 4 | Data RAM write data |

## Verification
The checker watches the cycle-level protocol on every cycle:
- a read strobe lasts exactly one cycle and is always followed by an accumulator write;
- exactly one high-nibble destination is written;
- the last-page variant forces the page bits;
- the RAM address equals the offset that was read.

Only the bench's scenarios can show that the nibbles land in the right places for several page, offset and data combinations. The same holds for page-boundary lookups, for register changes after acceptance, and for a start request during a read cycle being dropped.

// File: rtl/trd_pkg.sv
// Shared types of the table-read address unit.
package trd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } trd_state_e;

    typedef enum logic {
        PG_CURRENT = 1'b0,
        PG_LAST    = 1'b1
    } trd_page_e;

    typedef enum logic {
        DST_REG = 1'b0,
        DST_RAM = 1'b1
    } trd_dest_e;
endpackage

// File: rtl/trd_addr_gen.sv
// Forms the program-memory lookup address from a page and a two-nibble offset.
// Assumes the page given is already the advanced program counter page.
module trd_addr_gen
    import trd_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int NIB_W  = 4
) (
    input  trd_page_e                  page_sel,
    input  logic [PAGE_W-1:0]          cur_page,
    input  logic [NIB_W-1:0]           r1,
    input  logic [NIB_W-1:0]           r0,
    output logic [PAGE_W+2*NIB_W-1:0]  addr
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

    logic [PAGE_W-1:0] page;

    // Choose between the program counter page and the fixed last page.
    always_comb begin
        page = (page_sel == PG_LAST) ? LAST_PAGE : cur_page;
    end

    assign addr = {page, r1, r0};
endmodule

// File: rtl/trd_seq.sv
// Three-state sequencer: accept, one read cycle, one write cycle.
// Latches the lookup address, destination and RAM offset on acceptance.
// Assumes start may be issued in idle or write state; it is dropped in read state.
module trd_seq
    import trd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  trd_dest_e         dest_in,
    input  logic [OFS_W-1:0]  ofs_in,
    output trd_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output trd_dest_e         dest_q,
    output logic [OFS_W-1:0]  ofs_q
);
    logic       accept;
    trd_state_e state_nx;

    assign accept = start && (state != ST_READ);

    // Next-state selection.
    always_comb begin
        case (state)
            ST_READ: state_nx = ST_WRITE;
            default: state_nx = accept ? ST_READ : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the operands of an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dest_q <= DST_REG;
            ofs_q  <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
            dest_q <= dest_in;
            ofs_q  <= ofs_in;
        end
    end
endmodule

// File: rtl/trd_split.sv
// Splits the fetched byte: low nibble to the accumulator, high nibble to
// register four or to data RAM. Assumes the byte is stable during the write phase.
module trd_split
    import trd_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               wr_phase,
    input  trd_dest_e          dest,
    input  logic [2*NIB_W-1:0] ofs,
    input  logic [2*NIB_W-1:0] byte_in,
    output logic               acc_we,
    output logic [NIB_W-1:0]   acc_wdata,
    output logic               r4_we,
    output logic [NIB_W-1:0]   r4_wdata,
    output logic               ram_we,
    output logic [2*NIB_W-1:0] ram_addr,
    output logic [NIB_W-1:0]   ram_wdata
);
    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;

    assign lo_nib = byte_in[NIB_W-1:0];
    assign hi_nib = byte_in[2*NIB_W-1:NIB_W];

    // Route nibbles and enables to their destinations.
    always_comb begin
        acc_we    = wr_phase;
        acc_wdata = lo_nib;
        r4_we     = wr_phase && (dest == DST_REG);
        r4_wdata  = hi_nib;
        ram_we    = wr_phase && (dest == DST_RAM);
        ram_wdata = hi_nib;
        ram_addr  = ofs;
    end
endmodule

// File: rtl/trd_unit.sv
// Top of the paged table-read address unit.
// Assumes program memory registers rom_data one cycle after rom_rd.
module trd_unit
    import trd_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int NIB_W  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                sel_last,
    input  logic                                to_ram,
    input  logic [PAGE_W-1:0]                   pc_page,
    input  logic [NIB_W-1:0]                    r0,
    input  logic [NIB_W-1:0]                    r1,
    input  logic [2*NIB_W-1:0]                  rom_data,
    output logic [PAGE_W+2*NIB_W-1:0]           rom_addr,
    output logic                                rom_rd,
    output logic                                hold_pc,
    output logic                                acc_we,
    output logic [NIB_W-1:0]                    acc_wdata,
    output logic                                r4_we,
    output logic [NIB_W-1:0]                    r4_wdata,
    output logic                                ram_we,
    output logic [2*NIB_W-1:0]                  ram_addr,
    output logic [NIB_W-1:0]                    ram_wdata
);
    localparam int OFS_W  = 2 * NIB_W;
    localparam int ADDR_W = PAGE_W + OFS_W;

    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] addr_q;
    logic [OFS_W-1:0]  ofs_q;
    trd_dest_e         dest_q;
    trd_state_e        state;

    trd_addr_gen #(.PAGE_W(PAGE_W), .NIB_W(NIB_W)) u_addr (
        .page_sel (trd_page_e'(sel_last)),
        .cur_page (pc_page),
        .r1       (r1),
        .r0       (r0),
        .addr     (addr_c)
    );

    trd_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_in (addr_c),
        .dest_in (trd_dest_e'(to_ram)),
        .ofs_in  ({r1, r0}),
        .state   (state),
        .addr_q  (addr_q),
        .dest_q  (dest_q),
        .ofs_q   (ofs_q)
    );

    trd_split #(.NIB_W(NIB_W)) u_split (
        .wr_phase  (state == ST_WRITE),
        .dest      (dest_q),
        .ofs       (ofs_q),
        .byte_in   (rom_data),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .r4_we     (r4_we),
        .r4_wdata  (r4_wdata),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    assign rom_addr = addr_q;
    assign rom_rd   = (state == ST_READ);
    assign hold_pc  = (state == ST_READ);
endmodule

// File: rtl/trd_unit_chk.sv
// Protocol checker for trd_unit, attached by bind.
module trd_unit_chk #(
    parameter int PAGE_W = 4,
    parameter int NIB_W  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       sel_last,
    input logic                       rom_rd,
    input logic [PAGE_W+2*NIB_W-1:0]  rom_addr,
    input logic                       acc_we,
    input logic                       r4_we,
    input logic                       ram_we,
    input logic [2*NIB_W-1:0]         ram_addr
);
    localparam int OFS_W  = 2 * NIB_W;
    localparam int ADDR_W = PAGE_W + OFS_W;

    // R2: an accepted start produces a read cycle next.
    p_start_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rom_rd) |=> rom_rd);

    // R3: last-page variant forces the page bits.
    p_last_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && $past(sel_last)) |-> (rom_addr[ADDR_W-1:OFS_W] == '1));

    // R8: read lasts one cycle.
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> !rom_rd);

    // R5: each read is followed by the accumulator write.
    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> acc_we);

    // R5: accumulator write only after a read.
    p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> $past(rom_rd));

    // R6: exactly one high-nibble destination per write.
    p_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (r4_we != ram_we));

    // R7: RAM address equals the offset that was read.
    p_ram_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == $past(rom_addr[OFS_W-1:0])));
endmodule

bind trd_unit trd_unit_chk #(.PAGE_W(PAGE_W), .NIB_W(NIB_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sel_last (sel_last),
    .rom_rd   (rom_rd),
    .rom_addr (rom_addr),
    .acc_we   (acc_we),
    .r4_we    (r4_we),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/trd_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for trd_unit.
module trd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sel_last = 1'b0;
    logic        to_ram = 1'b0;
    logic [3:0]  pc_page = '0;
    logic [3:0]  r0 = '0;
    logic [3:0]  r1 = '0;
    logic [7:0]  rom_data = '0;
    logic [11:0] rom_addr;
    logic        rom_rd, hold_pc, acc_we, r4_we, ram_we;
    logic [3:0]  acc_wdata, r4_wdata, ram_wdata;
    logic [7:0]  ram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic       to_ram;
        logic [3:0] acc;
        logic [3:0] hi;
        logic [7:0] ra;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    trd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_last(sel_last),
        .to_ram(to_ram), .pc_page(pc_page), .r0(r0), .r1(r1),
        .rom_data(rom_data), .rom_addr(rom_addr), .rom_rd(rom_rd),
        .hold_pc(hold_pc), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .r4_we(r4_we), .r4_wdata(r4_wdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    function automatic logic [7:0] rom_fn(input logic [11:0] a);
        return 8'(a[7:0] * 8'd7 + {4'h0, a[11:8]} * 8'd29 + 8'd3);
    endfunction

    // Synchronous program memory model.
    always @(posedge clk) if (rom_rd) rom_data <= rom_fn(rom_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: pops expected writes and compares.
    always @(negedge clk) begin
        if (rst_n && (acc_we || r4_we || ram_we)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(acc_we && acc_wdata == e.acc, "R5 acc nibble", int'(acc_wdata), int'(e.acc));
                if (e.to_ram) begin
                    chk(ram_we && !r4_we, "R6 ram enable", int'({r4_we, ram_we}), 1);
                    chk(ram_wdata == e.hi, "R6 ram nibble", int'(ram_wdata), int'(e.hi));
                    chk(ram_addr == e.ra, "R7 ram address", int'(ram_addr), int'(e.ra));
                end else begin
                    chk(r4_we && !ram_we, "R5 r4 enable", int'({r4_we, ram_we}), 2);
                    chk(r4_wdata == e.hi, "R5 r4 nibble", int'(r4_wdata), int'(e.hi));
                end
            end
        end
    end

    // Driver: issue one lookup at a negedge, returns at the write-cycle negedge.
    task automatic run_op(input logic lst, input logic dst, input logic [3:0] pg,
                          input logic [3:0] a1, input logic [3:0] a0,
                          input bit scramble, input bit restart, input string req);
        logic [11:0] ea;
        exp_t e;
        ea = {lst ? 4'hF : pg, a1, a0};
        e.to_ram = dst;
        e.acc = rom_fn(ea)[3:0];
        e.hi = rom_fn(ea)[7:4];
        e.ra = {a1, a0};
        sb_q.push_back(e);
        sel_last = lst; to_ram = dst; pc_page = pg; r1 = a1; r0 = a0; start = 1'b1;
        @(negedge clk);
        chk(rom_rd && hold_pc, {req, " read strobe"}, int'({rom_rd, hold_pc}), 3);
        chk(rom_addr == ea, {req, " address"}, int'(rom_addr), int'(ea));
        start = restart;
        if (scramble || restart) begin
            r1 = ~a1; r0 = ~a0; sel_last = ~lst; to_ram = ~dst; pc_page = ~pg;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!rom_rd && !hold_pc, "R8 read ends", int'({rom_rd, hold_pc}), 0);
        if (restart) chk(rom_addr == ea, "R9 address kept", int'(rom_addr), int'(ea));
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rom_rd && !hold_pc && !acc_we && !r4_we && !ram_we, "R1 in reset",
            int'({rom_rd, hold_pc, acc_we, r4_we, ram_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rom_rd && !hold_pc && !acc_we && !r4_we && !ram_we, "R1 after reset",
            int'({rom_rd, hold_pc, acc_we, r4_we, ram_we}), 0);
        run_op(1'b0, 1'b0, 4'h3, 4'hA, 4'h5, 1'b0, 1'b0, "R2");
        @(negedge clk);
        run_op(1'b1, 1'b0, 4'h2, 4'h1, 4'hC, 1'b0, 1'b0, "R3");
        @(negedge clk);
        run_op(1'b0, 1'b1, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0, "R4");
        @(negedge clk);
        run_op(1'b0, 1'b1, 4'h7, 4'hE, 4'h9, 1'b1, 1'b0, "R7");
        // Back-to-back lookups (R8).
        run_op(1'b1, 1'b1, 4'h0, 4'hF, 4'hF, 1'b0, 1'b0, "R8");
        run_op(1'b0, 1'b0, 4'hF, 4'h4, 4'h2, 1'b0, 1'b0, "R8");
        run_op(1'b0, 1'b1, 4'h5, 4'h6, 4'hB, 1'b1, 1'b0, "R6");
        @(negedge clk);
        run_op(1'b0, 1'b0, 4'h9, 4'h3, 4'h8, 1'b0, 1'b1, "R9");
        @(negedge clk);
        chk(!rom_rd && !acc_we, "R9 no extra op", int'({rom_rd, acc_we}), 0);
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R5 all writes seen", sb_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule